// File: doc/BRIEF.md
# Ethernet Controller Host Command and Interrupt Registers

This block is the 16-bit register face of an Ethernet controller. A host reads and writes registers by index. The index is the host address shifted right by `IDX_SHIFT`. Each register applies its own write rule: a plain store, a masked store, an inverted store, a store allowed only while the controller sits in software reset, or write-one-to-clear. Writes to the command register become one-cycle strobes on `cmd_pulse`. The DMA, timer and datapath engines consume these strobes. When those engines finish, they send pulses back on `cmd_done`, which clears command bits, and on `evt_set`, which sets interrupt status bits.

A level interrupt `irq` is driven from the AND of the interrupt mask and the interrupt status. Read data is registered and appears on `host_rdata` one cycle after the read request.

Top module: `nic_host_regs`

## Requirements
- R1: After hardware reset, reads return the following values: command (index 0x00) 0x0094, transmit control (0x03) 0x0101, receive control (0x02) 0x0020, end-of-buffer count (0x13) 0x02F8, revision (0x28) 0x0004, and 0 for every other register. Also after reset, `irq` is low and `cmd_pulse` is zero.
- R2: The command register's bit 7 is the software-reset flag. While this flag is set, a command write whose bit 7 is 0 only clears the flag. All other bits are left unchanged and `cmd_pulse` stays zero.
- R3: Any other command write ORs (data & 0x03BF) into the command register. In the cycle after the write, `cmd_pulse` equals (data & 0x03BF) for one cycle. The bit positions are: 0 halt transmit, 1 transmit, 2 receiver disable, 3 receiver enable, 4 stop timer, 5 start timer, 7 software reset, 8 read resource, 9 load address table.
- R4: A command write with bit 7 set also clears command bits 9, 8, 1 and 0 and sets bits 7 and 2.
- R5: Each bit set on `cmd_done` clears that command bit at the next edge. Bits written to the command register in the same cycle are applied after the clear.
- R6: `irq` is high exactly when (mask & status) is nonzero. The mask register (index 0x04) is stored as data & 0x7FFF.
- R7: A write to the status register (index 0x05) clears each status bit that is written 1 and is currently set. Clearing status bit 5 this way raises `cmd_pulse` bit 8 in the next cycle.
- R8: Each bit set on `evt_set` sets that status bit. It wins over a host clear of the same bit in the same cycle.
- R9: The data configuration register (index 0x01, mask 0xBFFF) and the second configuration register (index 0x3F, mask 0xF017) accept writes only while command bit 7 is set. At other times such writes leave them unchanged.
- R10: The following registers store a modified form of the written data:
  - Receive control stores data & 0xFFE0.
  - Transmit control stores data & 0xF000.
  - The four resource pointers (indices 0x15 to 0x18) store data & 0xFFFE.
  - The end-of-buffer count stores data unchanged.
- R11: The three tally counters (indices 0x2C to 0x2E) store the bitwise inverse of the written data. The revision register and the address-table ports (indices 0x22 to 0x24) ignore writes; the table ports read 0.
- R12: A read of an index that is not implemented returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| host_wr | input | 1 | Host write request, one register per cycle |
| host_rd | input | 1 | Host read request |
| host_addr | input | ADDR_W | Host address; register index is host_addr >> IDX_SHIFT |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data, valid the cycle after host_rd |
| cmd_done | input | 16 | Completion pulses that clear command bits |
| evt_set | input | 16 | Event pulses that set status bits |
| cmd_pulse | output | 16 | One-cycle command strobes, same bit positions as the command register |
| irq | output | 1 | Level interrupt |

## Verification
Register writes, `cmd_done` and `evt_set` all take effect at the edge that samples them. As a result, `cmd_pulse` and `irq` are due just after that edge, and a read issued in the next cycle sees the new contents. `host_rdata` is due one edge after the read request.

The bench drives all inputs on the falling edge and checks one time unit after the rising edge that captures them. A model kept in the bench is advanced at the same point in each cycle, so every expected value matches the cycle in which it is compared.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
    localparam int DW     = 16;
    localparam int IDX_W  = 6;
    localparam int NPTR   = 4;
    localparam int NTALLY = 3;

    typedef logic [DW-1:0]    word_t;
    typedef logic [IDX_W-1:0] idx_t;

    // register indices that neighbouring software decodes
    localparam idx_t IX_CMD    = 6'h00;
    localparam idx_t IX_DCFG   = 6'h01;
    localparam idx_t IX_RXC    = 6'h02;
    localparam idx_t IX_TXC    = 6'h03;
    localparam idx_t IX_MASK   = 6'h04;
    localparam idx_t IX_STAT   = 6'h05;
    localparam idx_t IX_EOBC   = 6'h13;
    localparam idx_t IX_PTR0   = 6'h15;
    localparam idx_t IX_REV    = 6'h28;
    localparam idx_t IX_TALLY0 = 6'h2C;
    localparam idx_t IX_DCFG2  = 6'h3F;

    localparam word_t CMD_MASK   = 16'h03BF;
    localparam word_t DCFG_MASK  = 16'hBFFF;
    localparam word_t DCFG2_MASK = 16'hF017;
    localparam word_t RXC_MASK   = 16'hFFE0;
    localparam word_t TXC_MASK   = 16'hF000;
    localparam word_t IMASK_MASK = 16'h7FFF;
    localparam word_t PTR_MASK   = 16'hFFFE;

    localparam word_t CMD_RST  = 16'h0094;
    localparam word_t TXC_RST  = 16'h0101;
    localparam word_t RXC_RST  = 16'h0020;
    localparam word_t EOBC_RST = 16'h02F8;
    localparam word_t REV_VAL  = 16'h0004;

    localparam int B_HALT  = 0;
    localparam int B_TX    = 1;
    localparam int B_RXDIS = 2;
    localparam int B_SWRST = 7;
    localparam int B_RDRES = 8;
    localparam int B_LDTBL = 9;
    localparam int ST_BUFX = 5;

    typedef struct packed {
        word_t cmd;
        word_t pulse;
    } cmd_state_t;

    typedef struct packed {
        word_t mask;
        word_t stat;
    } irq_state_t;

    typedef struct packed {
        word_t                      dcfg;
        word_t                      dcfg2;
        word_t                      rxc;
        word_t                      txc;
        word_t                      eobc;
        logic [NPTR-1:0][DW-1:0]    ptr;
        logic [NTALLY-1:0][DW-1:0]  tally;
    } cfg_state_t;
endpackage

// File: rtl/nic_cmd_ctl.sv
module nic_cmd_ctl
    import nic_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wdata,
    input  word_t done,
    input  logic  rdres_req,
    output word_t cmd_q,
    output word_t pulse_q
);
    cmd_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        st_d.cmd   = st_q.cmd & ~done;
        if (wr_en) begin
            if (st_q.cmd[B_SWRST] && !wdata[B_SWRST]) begin
                // leaving reset: nothing else happens
                st_d.cmd[B_SWRST] = 1'b0;
            end else begin
                st_d.cmd   = st_d.cmd | (wdata & CMD_MASK);
                st_d.pulse = wdata & CMD_MASK;
                if (wdata[B_SWRST]) begin
                    st_d.cmd[B_LDTBL] = 1'b0;
                    st_d.cmd[B_RDRES] = 1'b0;
                    st_d.cmd[B_TX]    = 1'b0;
                    st_d.cmd[B_HALT]  = 1'b0;
                    st_d.cmd[B_SWRST] = 1'b1;
                    st_d.cmd[B_RXDIS] = 1'b1;
                end
            end
        end
        if (rdres_req) st_d.pulse[B_RDRES] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmd   <= CMD_RST;
            st_q.pulse <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q   = st_q.cmd;
    assign pulse_q = st_q.pulse;
endmodule

// File: rtl/nic_irq_ctl.sv
module nic_irq_ctl
    import nic_regs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mask_wr,
    input  logic  stat_wr,
    input  word_t wdata,
    input  word_t evt_set,
    output word_t mask_q,
    output word_t stat_q,
    output logic  rdres_req,
    output logic  irq
);
    irq_state_t st_d, st_q;
    word_t      clr;

    always_comb begin
        st_d = st_q;
        clr  = stat_wr ? (wdata & st_q.stat) : '0;
        // event set applied last, so it wins over a clear of the same bit
        st_d.stat = (st_q.stat & ~clr) | evt_set;
        if (mask_wr) st_d.mask = wdata & IMASK_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdres_req = clr[ST_BUFX];
    assign mask_q    = st_q.mask;
    assign stat_q    = st_q.stat;
    assign irq       = |(st_q.mask & st_q.stat);
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
    import nic_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  idx_t       idx,
    input  word_t      wdata,
    input  logic       in_reset,
    output cfg_state_t cfg_q
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (idx == IX_DCFG  && in_reset) st_d.dcfg  = wdata & DCFG_MASK;
            if (idx == IX_DCFG2 && in_reset) st_d.dcfg2 = wdata & DCFG2_MASK;
            if (idx == IX_RXC)  st_d.rxc  = wdata & RXC_MASK;
            if (idx == IX_TXC)  st_d.txc  = wdata & TXC_MASK;
            if (idx == IX_EOBC) st_d.eobc = wdata;
            for (int k = 0; k < NPTR; k++) begin
                if (idx == IX_PTR0 + idx_t'(k)) st_d.ptr[k] = wdata & PTR_MASK;
            end
            for (int k = 0; k < NTALLY; k++) begin
                if (idx == IX_TALLY0 + idx_t'(k)) st_d.tally[k] = ~wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.rxc  <= RXC_RST;
            st_q.txc  <= TXC_RST;
            st_q.eobc <= EOBC_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q;
endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
    import nic_regs_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int IDX_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    input  logic [15:0]       cmd_done,
    input  logic [15:0]       evt_set,
    output logic [15:0]       cmd_pulse,
    output logic              irq
);
    idx_t       idx;
    word_t      cmd_q, mask_q, stat_q, rd_val, rdata_d, rdata_q;
    cfg_state_t cfg_q;
    logic       rdres_req;

    assign idx = idx_t'(host_addr >> IDX_SHIFT);

    nic_cmd_ctl u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_wr && idx == IX_CMD),
        .wdata     (host_wdata),
        .done      (cmd_done),
        .rdres_req (rdres_req),
        .cmd_q     (cmd_q),
        .pulse_q   (cmd_pulse)
    );

    nic_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr   (host_wr && idx == IX_MASK),
        .stat_wr   (host_wr && idx == IX_STAT),
        .wdata     (host_wdata),
        .evt_set   (evt_set),
        .mask_q    (mask_q),
        .stat_q    (stat_q),
        .rdres_req (rdres_req),
        .irq       (irq)
    );

    nic_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr),
        .idx      (idx),
        .wdata    (host_wdata),
        .in_reset (cmd_q[B_SWRST]),
        .cfg_q    (cfg_q)
    );

    always_comb begin
        case (idx)
            IX_CMD:   rd_val = cmd_q;
            IX_DCFG:  rd_val = cfg_q.dcfg;
            IX_RXC:   rd_val = cfg_q.rxc;
            IX_TXC:   rd_val = cfg_q.txc;
            IX_MASK:  rd_val = mask_q;
            IX_STAT:  rd_val = stat_q;
            IX_EOBC:  rd_val = cfg_q.eobc;
            IX_REV:   rd_val = REV_VAL;
            IX_DCFG2: rd_val = cfg_q.dcfg2;
            default:  rd_val = '0;
        endcase
        for (int k = 0; k < NPTR; k++) begin
            if (idx == IX_PTR0 + idx_t'(k)) rd_val = cfg_q.ptr[k];
        end
        for (int k = 0; k < NTALLY; k++) begin
            if (idx == IX_TALLY0 + idx_t'(k)) rd_val = cfg_q.tally[k];
        end
        rdata_d = host_rd ? rd_val : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign host_rdata = rdata_q;
endmodule

// File: rtl/nic_host_regs_chk.sv
module nic_host_regs_chk #(
    parameter int ADDR_W    = 7,
    parameter int IDX_SHIFT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic [ADDR_W-1:0] host_addr,
    input logic [15:0]       host_wdata,
    input logic [15:0]       host_rdata,
    input logic [15:0]       cmd_done,
    input logic [15:0]       cmd_pulse,
    input logic              irq,
    input logic              cr_rst
);
    logic [5:0] ix;
    assign ix = 6'(host_addr >> IDX_SHIFT);

    // R2
    rel_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ix == 6'h00 && cr_rst && !host_wdata[7]) |=> (cmd_pulse == 16'h0000));

    // R3
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse != 16'h0000) |-> $past(host_wr));

    // R4
    swrst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ix == 6'h00 && host_wdata[7] && !cmd_done[7]) |=> cr_rst);

    // R6
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ix == 6'h04 && host_wdata == 16'h0000) |=> !irq);

    // R11
    rev_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && ix == 6'h28) |=> (host_rdata == 16'h0004));
endmodule

bind nic_host_regs nic_host_regs_chk #(.ADDR_W(ADDR_W), .IDX_SHIFT(IDX_SHIFT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cmd_done   (cmd_done),
    .cmd_pulse  (cmd_pulse),
    .irq        (irq),
    .cr_rst     (cmd_q[7])
);

// File: tb/nic_host_regs_test.sv
module nic_host_regs_test;
    localparam int ADDR_W = 7;
    localparam int SHIFT  = 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0, host_rd = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [15:0]       host_wdata = '0, cmd_done = '0, evt_set = '0;
    logic [15:0]       host_rdata, cmd_pulse;
    logic              irq;

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    nic_host_regs #(.ADDR_W(ADDR_W), .IDX_SHIFT(SHIFT)) uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_done(cmd_done), .evt_set(evt_set), .cmd_pulse(cmd_pulse), .irq(irq)
    );

    // bench model of the register file
    logic [15:0] m_cmd, m_dcfg, m_dcfg2, m_rxc, m_txc, m_mask, m_stat, m_eobc;
    logic [15:0] m_ptr [4];
    logic [15:0] m_tal [3];

    task automatic model_reset();
        m_cmd = 16'h0094; m_dcfg = 0; m_dcfg2 = 0; m_rxc = 16'h0020;
        m_txc = 16'h0101; m_mask = 0; m_stat = 0; m_eobc = 16'h02F8;
        for (int k = 0; k < 4; k++) m_ptr[k] = 0;
        for (int k = 0; k < 3; k++) m_tal[k] = 0;
    endtask

    function automatic logic [15:0] exp_read(input logic [5:0] ix);
        if (ix >= 6'h15 && ix <= 6'h18) return m_ptr[ix - 6'h15];
        if (ix >= 6'h2C && ix <= 6'h2E) return m_tal[ix - 6'h2C];
        case (ix)
            6'h00: return m_cmd;
            6'h01: return m_dcfg;
            6'h02: return m_rxc;
            6'h03: return m_txc;
            6'h04: return m_mask;
            6'h05: return m_stat;
            6'h13: return m_eobc;
            6'h28: return 16'h0004;
            6'h3F: return m_dcfg2;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] ix);
        if (ix == 6'h00) return "R3";
        if (ix == 6'h01 || ix == 6'h3F) return "R9";
        if (ix == 6'h04) return "R6";
        if (ix == 6'h05) return "R7";
        if (ix == 6'h02 || ix == 6'h03 || ix == 6'h13 || (ix >= 6'h15 && ix <= 6'h18)) return "R10";
        if (ix == 6'h28 || (ix >= 6'h22 && ix <= 6'h24) || (ix >= 6'h2C && ix <= 6'h2E)) return "R11";
        return "R12";
    endfunction

    // advance the model by one cycle; returns the strobes due after the edge
    task automatic model_step(input logic wr, input logic [5:0] ix, input logic [15:0] d,
                              input logic [15:0] ev, input logic [15:0] dn,
                              output logic [15:0] pls);
        logic [15:0] ncmd, clr;
        logic        rst_now;
        rst_now = m_cmd[7];
        pls  = 0;
        clr  = 0;
        ncmd = m_cmd & ~dn;
        if (wr) begin
            if (ix == 6'h00) begin
                if (rst_now && !d[7]) ncmd[7] = 1'b0;
                else begin
                    ncmd = ncmd | (d & 16'h03BF);
                    pls  = d & 16'h03BF;
                    if (d[7]) ncmd = (ncmd & ~16'h0303) | 16'h0084;
                end
            end
            if (ix == 6'h05) clr = d & m_stat;
            if (ix == 6'h04) m_mask = d & 16'h7FFF;
            if (ix == 6'h01 && rst_now) m_dcfg = d & 16'hBFFF;
            if (ix == 6'h3F && rst_now) m_dcfg2 = d & 16'hF017;
            if (ix == 6'h02) m_rxc = d & 16'hFFE0;
            if (ix == 6'h03) m_txc = d & 16'hF000;
            if (ix == 6'h13) m_eobc = d;
            if (ix >= 6'h15 && ix <= 6'h18) m_ptr[ix - 6'h15] = d & 16'hFFFE;
            if (ix >= 6'h2C && ix <= 6'h2E) m_tal[ix - 6'h2C] = ~d;
        end
        m_stat = (m_stat & ~clr) | ev;
        if (clr[5]) pls[8] = 1'b1;
        m_cmd = ncmd;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd, input logic [5:0] ix,
                         input logic [15:0] d, input logic [15:0] ev, input logic [15:0] dn);
        @(negedge clk);
        host_wr = wr; host_rd = rd;
        host_addr = {ix, 1'($urandom)};
        host_wdata = d; evt_set = ev; cmd_done = dn;
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input string tag, input logic [5:0] ix, input logic [15:0] d,
                            input logic [15:0] ev, input logic [15:0] dn);
        logic [15:0] pls;
        model_step(1'b1, ix, d, ev, dn, pls);
        drive(1'b1, 1'b0, ix, d, ev, dn);
        chk(tag, cmd_pulse, pls);
        chk("R6", {15'd0, irq}, {15'd0, |(m_mask & m_stat)});
    endtask

    task automatic do_event(input string tag, input logic [15:0] ev, input logic [15:0] dn);
        logic [15:0] pls;
        model_step(1'b0, 6'h00, 16'h0000, ev, dn, pls);
        drive(1'b0, 1'b0, 6'h00, 16'h0000, ev, dn);
        chk(tag, cmd_pulse, pls);
    endtask

    task automatic do_read(input string tag, input logic [5:0] ix);
        logic [15:0] e;
        e = exp_read(ix);
        drive(1'b0, 1'b1, ix, 16'h0000, 16'h0000, 16'h0000);
        chk(tag, host_rdata, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: all requirements, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", cmd_pulse, 16'h0000);
        chk("R1", {15'd0, irq}, 16'h0000);
        do_read("R1", 6'h00);
        do_read("R1", 6'h03);
        do_read("R1", 6'h02);
        do_read("R1", 6'h13);
        do_read("R1", 6'h28);
        do_read("R1", 6'h04);
        do_read("R1", 6'h01);

        // R9 configuration writable while in reset
        do_write("R9", 6'h01, 16'hFFFF, 0, 0);
        do_read("R9", 6'h01);
        do_write("R9", 6'h3F, 16'hFFFF, 0, 0);
        do_read("R9", 6'h3F);
        // R2 release only
        do_write("R2", 6'h00, 16'h0208, 0, 0);
        do_read("R2", 6'h00);
        // R9 now locked
        do_write("R9", 6'h01, 16'h1234, 0, 0);
        do_read("R9", 6'h01);
        do_write("R9", 6'h3F, 16'h0000, 0, 0);
        do_read("R9", 6'h3F);
        // R3 command bits and strobes
        do_write("R3", 6'h00, 16'hFC4B, 0, 0);
        do_read("R3", 6'h00);
        chk("R3", cmd_pulse, 16'h0000);
        // R5 completion clears
        do_event("R5", 0, 16'h0003);
        do_read("R5", 6'h00);
        do_write("R5", 6'h00, 16'h0002, 0, 16'h0002);
        do_read("R5", 6'h00);
        // R4 software reset
        do_write("R4", 6'h00, 16'h0383, 0, 0);
        do_read("R4", 6'h00);
        // R10 / R11 masked and special stores
        do_write("R10", 6'h02, 16'hFFFF, 0, 0);
        do_read("R10", 6'h02);
        do_write("R10", 6'h16, 16'hABCD, 0, 0);
        do_read("R10", 6'h16);
        do_write("R11", 6'h2D, 16'h00F0, 0, 0);
        do_read("R11", 6'h2D);
        do_write("R11", 6'h28, 16'hFFFF, 0, 0);
        do_read("R11", 6'h28);
        do_write("R11", 6'h23, 16'hFFFF, 0, 0);
        do_read("R11", 6'h23);
        do_read("R12", 6'h30);
        // R6 / R7 / R8 interrupt path
        do_write("R6", 6'h04, 16'hFFFF, 0, 0);
        do_read("R6", 6'h04);
        do_event("R8", 16'h00A0, 0);
        do_write("R7", 6'h05, 16'h0020, 0, 0);
        do_read("R7", 6'h05);
        do_write("R8", 6'h05, 16'h0080, 16'h0080, 0);
        do_read("R8", 6'h05);
        do_write("R7", 6'h05, 16'h0020, 0, 0);
        do_write("R7", 6'h05, 16'hFFFF, 0, 0);
        do_read("R7", 6'h05);

        // constrained random phase
        for (int i = 0; i < 500; i++) begin
            logic [5:0]  ix;
            logic [15:0] d, ev, dn;
            int          r;
            r = $urandom % 8;
            if (r == 0)      ix = 6'h00;
            else if (r == 1) ix = 6'h05;
            else if (r == 2) ix = 6'h04;
            else             ix = 6'($urandom);
            d  = 16'($urandom);
            ev = ($urandom % 3 == 0) ? 16'($urandom) : 16'h0000;
            dn = ($urandom % 5 == 0) ? 16'($urandom) : 16'h0000;
            do_write(tag_of(ix), ix, d, ev, dn);
            ix = 6'($urandom);
            do_read(tag_of(ix), ix);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule